// File: doc/BRIEF.md
# Supply Controller Mode Sequencer

The sequencer is the mode state machine of a power-supply companion controller. It holds the operating mode and moves between modes on four kinds of event. A 1 ms timebase tick drives two timed intervals. A supply-low flag from the analog monitor forces the block back to Reset. A wake-up event ends the low-power modes. Mode requests, already decoded from host serial writes, choose the running mode. From its mode the block drives a reset-output request and the enable for an external watchdog.

The modes and their codes are Reset (0), Normal Request (1), Normal (2), Standby (3), Stop (4), Sleep (5), Normal Debug (6), Standby Debug (7) and Stop Debug (8). Reset lasts a fixed number of ticks and then hands over to Normal Request. In Normal Request the host must choose Normal or Standby within a timeout, or the block falls back to Reset. A one-cycle debug-entry strobe received in Normal Request sets a debug flag. While that flag is set, the running modes are the debug variants, in which the watchdog is never enabled. The flag is cleared only by supply-low or by the reset input.

The transitions are named as follows:
- RST_EXPIRE: Reset to Normal Request.
- NR_TIMEOUT: Normal Request to Reset.
- NR_SELECT: Normal Request to a Normal or Standby mode, plain or debug.
- RUN_SWITCH: between the running modes, or into Stop or Sleep.
- STOP_WAKE: Stop or Stop Debug to Normal Request.
- SLEEP_WAKE: Sleep to Reset.
- SUPPLY_LOW: any mode to Reset.

Top module: `supply_mode_seq`

## Requirements
- R1: After the reset input (active low) the mode is Reset (code 0), reset_req is 1 and wd_enable is 0.
- R2: In Reset, the mode changes to Normal Request (code 1) on the clock edge of the RST_TICKS-th tick (default 4) counted from entry to Reset. Cycles without a tick do not advance the count.
- R3: In Normal Request, the mode changes to Reset on the edge of the TO_TICKS-th tick (default 350) counted from entry, unless a valid Normal or Standby request arrives. A valid request in the same cycle as the last tick takes effect instead.
- R4: In Normal Request, a valid request with req_mode 0 (Normal) selects Normal, or Normal Debug if the debug flag is set. A request with req_mode 1 (Standby) selects Standby, or Standby Debug if the debug flag is set. Requests 2 (Stop) and 3 (Sleep) and wake-up events are ignored there.
- R5: In Normal or Standby, a valid request selects Normal (0→2), Standby (1→3), Stop (2→4) or Sleep (3→5). In Normal Debug or Standby Debug, it selects 0→6, 1→7, 2→8 or 3→5.
- R6: supply_low forces Reset on the next edge from every mode. It takes priority over requests and wake-up events in the same cycle and clears the debug flag.
- R7: In Stop or Stop Debug, a wake-up event moves the mode to Normal Request and requests are ignored. The debug flag survives the wake-up.
- R8: In Sleep, a wake-up event moves the mode to Reset. The reset count then restarts from zero.
- R9: wd_enable is 1 in Normal and Standby. In Stop it equals the value wd_in_stop had on the edge that entered Stop. It is 0 in every other mode, including all debug modes, whatever wd_in_stop is.
- R10: A dbg_entry pulse received in Normal Request sets the debug flag, which takes effect on requests from the following cycle.
- R11: reset_req is 1 exactly when the mode is Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle timebase tick |
| supply_low | input | 1 | Primary supply reported low |
| wake_evt | input | 1 | Wake-up event |
| req_valid | input | 1 | Decoded mode request strobe |
| req_mode | input | 2 | Requested mode: 0 Normal, 1 Standby, 2 Stop, 3 Sleep |
| dbg_entry | input | 1 | Debug-entry strobe |
| wd_in_stop | input | 1 | Keep watchdog running in Stop |
| mode | output | 4 | Current mode code |
| reset_req | output | 1 | Reset-output request |
| wd_enable | output | 1 | Watchdog enable |

## Verification
On every cycle the assertions check four things: supply-low forcing Reset, the wake-up exits from Stop and Sleep, Reset being left only for Normal Request, and the watchdog staying off in Reset and in every debug mode. Only the bench scenarios can show the tick-exact length of the reset and timeout intervals, the full request mapping from each running mode, and the capture of wd_in_stop at Stop entry. The same applies to the persistence of the debug flag across Stop and its clearing by supply-low.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

    typedef enum logic [3:0] {
        MD_RESET    = 4'd0,
        MD_NREQ     = 4'd1,
        MD_NORMAL   = 4'd2,
        MD_STANDBY  = 4'd3,
        MD_STOP     = 4'd4,
        MD_SLEEP    = 4'd5,
        MD_NORM_DBG = 4'd6,
        MD_STBY_DBG = 4'd7,
        MD_STOP_DBG = 4'd8
    } mode_e;

    typedef enum logic [1:0] {
        RQ_NORMAL  = 2'd0,
        RQ_STANDBY = 2'd1,
        RQ_STOP    = 2'd2,
        RQ_SLEEP   = 2'd3
    } req_e;

endpackage

// File: rtl/smseq_tick_cnt.sv
module smseq_tick_cnt #(
    parameter int RST_TICKS = 4,
    parameter int TO_TICKS  = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cnt_en,
    input  logic tick,
    output logic rst_done,
    output logic to_done
);
    localparam int MAX_TICKS = (RST_TICKS > TO_TICKS) ? RST_TICKS : TO_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TO_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MAX_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_en && tick && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rst_done = cnt_en && tick && (cnt_q == RST_LAST);
        to_done  = cnt_en && tick && (cnt_q == TO_LAST);
    end

endmodule

// File: rtl/smseq_next.sv
module smseq_next
    import smseq_pkg::*;
(
    input  mode_e      cur,
    input  logic       supply_low,
    input  logic       wake_evt,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       dbg_on,
    input  logic       rst_done,
    input  logic       to_done,
    output mode_e      nxt
);
    req_e rq;

    always_comb begin
        rq  = req_e'(req_mode);
        nxt = cur;
        if (supply_low) begin
            nxt = MD_RESET;                                   // SUPPLY_LOW
        end else begin
            unique case (cur)
                MD_RESET: begin
                    if (rst_done) nxt = MD_NREQ;              // RST_EXPIRE
                end
                MD_NREQ: begin
                    if (req_valid && rq == RQ_NORMAL)
                        nxt = dbg_on ? MD_NORM_DBG : MD_NORMAL;   // NR_SELECT
                    else if (req_valid && rq == RQ_STANDBY)
                        nxt = dbg_on ? MD_STBY_DBG : MD_STANDBY;  // NR_SELECT
                    else if (to_done)
                        nxt = MD_RESET;                       // NR_TIMEOUT
                end
                MD_NORMAL, MD_STANDBY: begin
                    if (req_valid) begin                      // RUN_SWITCH
                        unique case (rq)
                            RQ_NORMAL:  nxt = MD_NORMAL;
                            RQ_STANDBY: nxt = MD_STANDBY;
                            RQ_STOP:    nxt = MD_STOP;
                            RQ_SLEEP:   nxt = MD_SLEEP;
                        endcase
                    end
                end
                MD_NORM_DBG, MD_STBY_DBG: begin
                    if (req_valid) begin                      // RUN_SWITCH
                        unique case (rq)
                            RQ_NORMAL:  nxt = MD_NORM_DBG;
                            RQ_STANDBY: nxt = MD_STBY_DBG;
                            RQ_STOP:    nxt = MD_STOP_DBG;
                            RQ_SLEEP:   nxt = MD_SLEEP;
                        endcase
                    end
                end
                MD_STOP, MD_STOP_DBG: begin
                    if (wake_evt) nxt = MD_NREQ;              // STOP_WAKE
                end
                MD_SLEEP: begin
                    if (wake_evt) nxt = MD_RESET;             // SLEEP_WAKE
                end
                default: nxt = MD_RESET;
            endcase
        end
    end

endmodule

// File: rtl/smseq_out.sv
module smseq_out
    import smseq_pkg::*;
(
    input  mode_e      cur,
    input  logic       wd_stop_q,
    output logic [3:0] mode,
    output logic       reset_req,
    output logic       wd_enable
);
    always_comb begin
        mode      = cur;
        reset_req = 1'b0;
        wd_enable = 1'b0;
        unique case (cur)
            MD_RESET:               reset_req = 1'b1;
            MD_NORMAL, MD_STANDBY:  wd_enable = 1'b1;
            MD_STOP:                wd_enable = wd_stop_q;
            MD_NREQ, MD_SLEEP, MD_NORM_DBG,
            MD_STBY_DBG, MD_STOP_DBG: wd_enable = 1'b0;
            default:                reset_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/supply_mode_seq.sv
module supply_mode_seq
    import smseq_pkg::*;
#(
    parameter int RST_TICKS = 4,
    parameter int TO_TICKS  = 350
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       supply_low,
    input  logic       wake_evt,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       dbg_entry,
    input  logic       wd_in_stop,
    output logic [3:0] mode,
    output logic       reset_req,
    output logic       wd_enable
);
    mode_e state_q;
    mode_e state_d;
    logic  dbg_q;
    logic  wd_stop_q;
    logic  rst_done;
    logic  to_done;
    logic  cnt_clr;
    logic  cnt_en;

    assign cnt_clr = supply_low || (state_d != state_q);
    assign cnt_en  = (state_q == MD_RESET) || (state_q == MD_NREQ);

    smseq_tick_cnt #(
        .RST_TICKS (RST_TICKS),
        .TO_TICKS  (TO_TICKS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .cnt_en   (cnt_en),
        .tick     (tick_1ms),
        .rst_done (rst_done),
        .to_done  (to_done)
    );

    smseq_next u_next (
        .cur        (state_q),
        .supply_low (supply_low),
        .wake_evt   (wake_evt),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .dbg_on     (dbg_q),
        .rst_done   (rst_done),
        .to_done    (to_done),
        .nxt        (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= MD_RESET;
            dbg_q     <= 1'b0;
            wd_stop_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (supply_low)
                dbg_q <= 1'b0;
            else if (dbg_entry && state_q == MD_NREQ)
                dbg_q <= 1'b1;
            if (state_d == MD_STOP && state_q != MD_STOP)
                wd_stop_q <= wd_in_stop;
        end
    end

    smseq_out u_out (
        .cur       (state_q),
        .wd_stop_q (wd_stop_q),
        .mode      (mode),
        .reset_req (reset_req),
        .wd_enable (wd_enable)
    );

endmodule

// File: rtl/smseq_chk.sv
module smseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_low,
    input logic       wake_evt,
    input logic [3:0] mode,
    input logic       reset_req,
    input logic       wd_enable
);
    // R6
    supply_low_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (mode == 4'd0));

    // R2
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd0) |=> (mode == 4'd0 || mode == 4'd1));

    // R7
    stop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 4'd4 || mode == 4'd8) && wake_evt && !supply_low) |=> (mode == 4'd1));

    // R8
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd5 && wake_evt) |=> (mode == 4'd0));

    // R9
    dbg_wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 4'd6 || mode == 4'd5 || mode == 4'd1) |-> !wd_enable);

    // R11
    reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req == (mode == 4'd0));

    // R11
    reset_no_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !wd_enable);

endmodule

bind supply_mode_seq smseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .wake_evt   (wake_evt),
    .mode       (mode),
    .reset_req  (reset_req),
    .wd_enable  (wd_enable)
);

// File: tb/supply_mode_seq_tb.sv
`timescale 1ns/1ps
module supply_mode_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       supply_low = 1'b0;
    logic       wake_evt = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic       dbg_entry = 1'b0;
    logic       wd_in_stop = 1'b0;
    logic [3:0] mode;
    logic       reset_req;
    logic       wd_enable;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supply_mode_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1ms   (tick_1ms),
        .supply_low (supply_low),
        .wake_evt   (wake_evt),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .dbg_entry  (dbg_entry),
        .wd_in_stop (wd_in_stop),
        .mode       (mode),
        .reset_req  (reset_req),
        .wd_enable  (wd_enable)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        tick_1ms = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick_1ms = 1'b0;
    endtask

    task automatic request(int code);
        req_valid = 1'b1;
        req_mode  = 2'(code);
        step();
        req_valid = 1'b0;
    endtask

    task automatic wake();
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic to_nreq();
        do_reset();
        ticks(4);
    endtask

    task automatic pulse_dbg();
        dbg_entry = 1'b1;
        step();
        dbg_entry = 1'b0;
    endtask

    // Bring the sequencer to the given mode code through its normal inputs.
    task automatic goto_mode(int m);
        if (m == 0) begin
            do_reset();
        end else begin
            to_nreq();
            if (m >= 6) pulse_dbg();
            case (m)
                2, 6: request(0);
                3, 7: request(1);
                4:    begin request(0); request(2); end
                5:    begin request(0); request(3); end
                8:    begin request(0); request(2); end
                default: ;
            endcase
        end
    endtask

    function automatic int run_map(bit dbg, int code);
        int plain[4] = '{2, 3, 4, 5};
        int debug[4] = '{6, 7, 8, 5};
        return dbg ? debug[code] : plain[code];
    endfunction

    function automatic int wd_exp(int m, bit wis);
        if (m == 2 || m == 3) return 1;
        if (m == 4) return int'(wis);
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 mode", mode, 0);
        check("R1 reset_req", reset_req, 1);
        check("R1 wd_enable", wd_enable, 0);
        check("R11 reset_req in Reset", reset_req, 1);

        // R2: idle cycles do not count, 3 ticks stay, 4th leaves
        for (int i = 0; i < 10; i++) step();
        check("R2 no tick", mode, 0);
        ticks(3);
        check("R2 three ticks", mode, 0);
        ticks(1);
        check("R2 fourth tick", mode, 1);
        check("R11 reset_req in NREQ", reset_req, 0);

        // R3: timeout
        to_nreq();
        ticks(349);
        check("R3 before timeout", mode, 1);
        ticks(1);
        check("R3 timeout", mode, 0);
        to_nreq();
        ticks(349);
        tick_1ms = 1'b1;
        request(0);
        tick_1ms = 1'b0;
        check("R3 request wins at expiry", mode, 2);

        // R4: Stop/Sleep requests and wake ignored in NREQ
        to_nreq();
        request(2);
        check("R4 stop ignored", mode, 1);
        request(3);
        check("R4 sleep ignored", mode, 1);
        wake();
        check("R4 wake ignored", mode, 1);
        request(1);
        check("R4 standby select", mode, 3);

        // R5/R9/R10: sweep of start mode, request code and wd_in_stop
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 2; w++) begin
                    int start;
                    int exp;
                    start = (s == 0) ? 2 : (s == 1) ? 3 : (s == 2) ? 6 : 7;
                    goto_mode(start);
                    check("R10 debug select", mode, start);
                    wd_in_stop = w[0];
                    request(c);
                    exp = run_map(start >= 6, c);
                    check("R5 request map", mode, exp);
                    wd_in_stop = ~w[0];
                    step();
                    check("R9 wd_enable", wd_enable, wd_exp(exp, w[0]));
                    wd_in_stop = 1'b0;
                end
            end
        end

        // R7: Stop ignores requests, wake to NREQ, debug flag survives
        goto_mode(4);
        request(0);
        check("R7 request in Stop ignored", mode, 4);
        wake();
        check("R7 stop wake", mode, 1);
        goto_mode(8);
        request(1);
        check("R7 request in Stop Debug ignored", mode, 8);
        wake();
        check("R7 stop debug wake", mode, 1);
        request(0);
        check("R7 debug persists", mode, 6);

        // R8: Sleep wake restarts the reset count
        goto_mode(5);
        wake();
        check("R8 sleep wake", mode, 0);
        check("R11 reset_req after sleep", reset_req, 1);
        ticks(3);
        check("R8 count restarted", mode, 0);
        ticks(1);
        check("R8 count expiry", mode, 1);

        // R6: supply low from every mode, with competing inputs
        for (int m = 0; m < 9; m++) begin
            goto_mode(m);
            supply_low = 1'b1;
            wake_evt = 1'b1;
            req_valid = 1'b1;
            req_mode = 2'd0;
            tick_1ms = 1'b1;
            step();
            supply_low = 1'b0;
            wake_evt = 1'b0;
            req_valid = 1'b0;
            tick_1ms = 1'b0;
            check("R6 supply low", mode, 0);
            ticks(4);
            request(0);
            check("R6 debug cleared", mode, 2);
        end

        // R10: strobe outside NREQ does not set the flag
        goto_mode(2);
        pulse_dbg();
        request(2);
        wake();
        request(0);
        check("R10 strobe outside NREQ", mode, 2);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule